// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block protects a multiplexed address/data bus with even parity. A lower half carries a data word and its active-low byte enables; an optional upper half of the same shape is used when a wide transfer has been negotiated. When the local agent drives the bus, the block outputs the parity bit for each lower-half word one clock later, with an output enable that trails the bus output enable by one clock. When the upper half is valid, it does the same for the upper half.

When the local agent receives, the block computes parity over what it sampled. One clock later it compares that value with the parity bit that arrives, and one clock after that it reports any mismatch. A data-phase mismatch drops the data error line for one cycle. An address-phase mismatch drops the system error line instead. Each line has a sticky flag that holds the event until an explicit clear. Errors are only flagged: nothing is retried or corrected.

Top module: `bus_parity_unit`

## Requirements
- R1: While `par_oe` is high, `par_out` equals the XOR of every bit of `ad_lo` and `cbe_lo_n` from the previous cycle, so the word, its byte enables and the parity bit together hold an even number of ones. Bytes masked by the enables still count.
- R2: `par_oe` is high in exactly those cycles that follow a cycle with `ad_oe` high.
- R3: `par64_oe` is high only after a driven cycle that was an address phase with `req64` high, or a data phase with both `req64` and `ack64` high. While `par64_oe` is high, `par64_out` equals the XOR of the previous cycle's `ad_hi` and `cbe_hi_n`.
- R4: A received data phase in cycle k (`data_ph`=1, `addr_ph`=0, `ad_oe`=0) is checked against `par_in` and `par64_in` in cycle k+1. On a mismatch, `perr_n` is low for exactly cycle k+2.
- R5: A received address phase in cycle k (`addr_ph`=1) reports a mismatch on `serr_n` in cycle k+2 and never on `perr_n`. When both phase inputs are high, the address phase takes precedence.
- R6: `par64_in` is compared only when the upper half was valid in cycle k: an address phase needs `req64`, and a data phase needs both `req64` and `ack64`. Otherwise its value has no effect on the error lines.
- R7: A cycle the block drove itself (`ad_oe`=1), or a cycle with neither phase input high, never causes an error report, whatever `par_in` carries.
- R8: `perr_sticky` and `serr_sticky` become high in the same cycle as their error pulse and stay high until `sticky_clr` is sampled high. A clear sampled on the same edge as a new error leaves the flag set.
- R9: During and right after reset, `perr_n` and `serr_n` are high, and `par_oe`, `par64_oe` and both sticky flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_lo | input | AD_W | Lower address/data word on the bus |
| cbe_lo_n | input | AD_W/8 | Lower command / byte enables, active low |
| ad_hi | input | AD_W | Upper address/data word |
| cbe_hi_n | input | AD_W/8 | Upper command / byte enables, active low |
| ad_oe | input | 1 | Local agent drives the bus this cycle |
| addr_ph | input | 1 | Cycle is an address phase |
| data_ph | input | 1 | Cycle is a data phase with a target selected |
| req64 | input | 1 | Wide transfer requested |
| ack64 | input | 1 | Wide transfer acknowledged |
| par_in | input | 1 | Received lower parity, covering the previous cycle |
| par64_in | input | 1 | Received upper parity, covering the previous cycle |
| sticky_clr | input | 1 | Clears both sticky flags |
| par_out | output | 1 | Generated lower parity |
| par_oe | output | 1 | Output enable for `par_out` |
| par64_out | output | 1 | Generated upper parity |
| par64_oe | output | 1 | Output enable for `par64_out` |
| perr_n | output | 1 | Data-phase parity error pulse, active low |
| serr_n | output | 1 | Address-phase parity error pulse, active low |
| perr_sticky | output | 1 | Latched data-phase error |
| serr_sticky | output | 1 | Latched address-phase error |

## Verification
Two things can land on the same clock edge. One is a freshly detected error setting a sticky flag while `sticky_clr` asks to clear it. The other is a cycle flagged as both address and data phase, where one report line must win. The bench drives directed sequences in which the bad parity bit and the clear share a cycle, and in which both phase inputs are high with bad parity. It judges the sticky flag and the two report lines against a model that lets set win over clear and routes the error to `serr_n`. Random traffic also produces both collisions, so the same model judges them there.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_e;

   // Address qualification wins when both qualifiers are raised.
   function automatic phase_e phase_of(input logic addr_ph, input logic data_ph);
      if (addr_ph)      return PH_ADDR;
      else if (data_ph) return PH_DATA;
      else              return PH_IDLE;
   endfunction

   // Upper half carries meaningful parity only after wide negotiation.
   function automatic logic upper_valid(input phase_e ph, input logic req64, input logic ack64);
      case (ph)
         PH_ADDR: return req64;
         PH_DATA: return req64 & ack64;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/bpar_tree.sv
module bpar_tree #(
   parameter int W = 36
) (
   input  logic [W-1:0] d,
   output logic         p
);
   localparam int LVL = (W > 1) ? $clog2(W) : 0;
   localparam int N   = 1 << LVL;

   generate
      for (genvar l = 0; l <= LVL; l++) begin : g_lvl
         logic [(N >> l)-1:0] v;
         if (l == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_in
               if (i < W) begin : g_real
                  assign v[i] = d[i];
               end else begin : g_pad
                  assign v[i] = 1'b0;
               end
            end
         end else begin : g_node
            for (genvar i = 0; i < (N >> l); i++) begin : g_x
               assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
            end
         end
      end
   endgenerate

   assign p = g_lvl[LVL].v[0];

endmodule

// File: rtl/bpar_gen.sv
module bpar_gen
   import bpar_pkg::*;
#(
   parameter bit HAS_HI = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   ad_oe,
   input  phase_e ph,
   input  logic   req64,
   input  logic   ack64,
   input  logic   p_lo,
   input  logic   p_hi,
   output logic   par_out,
   output logic   par_oe,
   output logic   par64_out,
   output logic   par64_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_out <= 1'b0;
         par_oe  <= 1'b0;
      end else begin
         par_out <= ad_oe ? p_lo : 1'b0;
         par_oe  <= ad_oe;
      end
   end

   generate
      if (HAS_HI) begin : g_hi
         logic hi_drive;
         assign hi_drive = ad_oe & upper_valid(ph, req64, ack64);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               par64_out <= 1'b0;
               par64_oe  <= 1'b0;
            end else begin
               par64_out <= hi_drive ? p_hi : 1'b0;
               par64_oe  <= hi_drive;
            end
         end
      end else begin : g_no_hi
         assign par64_out = 1'b0;
         assign par64_oe  = 1'b0;
      end
   endgenerate

   // R2: parity enable only ever trails a driven bus cycle
   p_oe_trails_r2: assert property (@(posedge clk) disable iff (!rst_n)
      par_oe |-> $past(ad_oe));

   // R3: upper parity is never driven without lower parity
   p_hi_within_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      par64_oe |-> par_oe);

   // R3: upper parity needs a wide request in the covered cycle
   p_hi_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      par64_oe |-> $past(req64));

endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
   import bpar_pkg::*;
#(
   parameter bit HAS_HI = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   ad_oe,
   input  phase_e ph,
   input  logic   req64,
   input  logic   ack64,
   input  logic   p_lo,
   input  logic   p_hi,
   input  logic   par_in,
   input  logic   par64_in,
   input  logic   sticky_clr,
   output logic   perr_n,
   output logic   serr_n,
   output logic   perr_sticky,
   output logic   serr_sticky
);
   // stage 1: capture expected parity and qualifiers of the received cycle
   logic rx_addr_q, rx_data_q, exp_lo_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_addr_q <= 1'b0;
         rx_data_q <= 1'b0;
         exp_lo_q  <= 1'b0;
      end else begin
         rx_addr_q <= (ph == PH_ADDR) & ~ad_oe;
         rx_data_q <= (ph == PH_DATA) & ~ad_oe;
         exp_lo_q  <= p_lo;
      end
   end

   logic mis_hi;
   generate
      if (HAS_HI) begin : g_hi
         logic hi_q, exp_hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q     <= 1'b0;
               exp_hi_q <= 1'b0;
            end else begin
               hi_q     <= upper_valid(ph, req64, ack64) & ~ad_oe;
               exp_hi_q <= p_hi;
            end
         end
         assign mis_hi = hi_q & (exp_hi_q ^ par64_in);
      end else begin : g_no_hi
         assign mis_hi = 1'b0;
      end
   endgenerate

   // stage 2: compare with arriving parity, register the report
   logic bad, perr_set, serr_set, perr_q, serr_q;
   assign bad      = (exp_lo_q ^ par_in) | mis_hi;
   assign perr_set = rx_data_q & bad;
   assign serr_set = rx_addr_q & bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perr_q      <= 1'b0;
         serr_q      <= 1'b0;
         perr_sticky <= 1'b0;
         serr_sticky <= 1'b0;
      end else begin
         perr_q      <= perr_set;
         serr_q      <= serr_set;
         perr_sticky <= (perr_sticky & ~sticky_clr) | perr_set;
         serr_sticky <= (serr_sticky & ~sticky_clr) | serr_set;
      end
   end

   assign perr_n = ~perr_q;
   assign serr_n = ~serr_q;

   // R5: one event never reaches both report lines
   p_lines_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!perr_n && !serr_n));

   // R4: a data error report stems from a data phase two cycles earlier
   p_perr_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n |-> ($past(ph, 2) == PH_DATA));

   // R7: self-driven cycles never report
   p_own_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ad_oe, 2) |-> (perr_n && serr_n));

   // R8: flag is set whenever its pulse is present
   p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!perr_n |-> perr_sticky) and (!serr_n |-> serr_sticky));

   // R8: flag holds without a clear
   p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_sticky && !sticky_clr) |=> perr_sticky);

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
   import bpar_pkg::*;
#(
   parameter int AD_W   = 32,
   parameter bit HAS_HI = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AD_W-1:0]      ad_lo,
   input  logic [AD_W/8-1:0]    cbe_lo_n,
   input  logic [AD_W-1:0]      ad_hi,
   input  logic [AD_W/8-1:0]    cbe_hi_n,
   input  logic                 ad_oe,
   input  logic                 addr_ph,
   input  logic                 data_ph,
   input  logic                 req64,
   input  logic                 ack64,
   input  logic                 par_in,
   input  logic                 par64_in,
   input  logic                 sticky_clr,
   output logic                 par_out,
   output logic                 par_oe,
   output logic                 par64_out,
   output logic                 par64_oe,
   output logic                 perr_n,
   output logic                 serr_n,
   output logic                 perr_sticky,
   output logic                 serr_sticky
);
   localparam int BE_W  = AD_W / 8;
   localparam int COV_W = AD_W + BE_W;

   generate
      if (AD_W < 8 || (AD_W % 8) != 0) begin : g_bad_width
         $error("bus_parity_unit: AD_W must be a positive multiple of 8");
      end
   endgenerate

   phase_e ph;
   assign ph = phase_of(addr_ph, data_ph);

   logic p_lo, p_hi;

   bpar_tree #(.W(COV_W)) u_tree_lo (
      .d ({ad_lo, cbe_lo_n}),
      .p (p_lo)
   );

   generate
      if (HAS_HI) begin : g_tree_hi
         bpar_tree #(.W(COV_W)) u_tree_hi (
            .d ({ad_hi, cbe_hi_n}),
            .p (p_hi)
         );
      end else begin : g_tree_none
         assign p_hi = 1'b0;
      end
   endgenerate

   bpar_gen #(.HAS_HI(HAS_HI)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .ad_oe     (ad_oe),
      .ph        (ph),
      .req64     (req64),
      .ack64     (ack64),
      .p_lo      (p_lo),
      .p_hi      (p_hi),
      .par_out   (par_out),
      .par_oe    (par_oe),
      .par64_out (par64_out),
      .par64_oe  (par64_oe)
   );

   bpar_chk #(.HAS_HI(HAS_HI)) u_chk (
      .clk         (clk),
      .rst_n       (rst_n),
      .ad_oe       (ad_oe),
      .ph          (ph),
      .req64       (req64),
      .ack64       (ack64),
      .p_lo        (p_lo),
      .p_hi        (p_hi),
      .par_in      (par_in),
      .par64_in    (par64_in),
      .sticky_clr  (sticky_clr),
      .perr_n      (perr_n),
      .serr_n      (serr_n),
      .perr_sticky (perr_sticky),
      .serr_sticky (serr_sticky)
   );

   // R9: reporting lines idle whenever there is no sticky record
   p_idle_without_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!perr_sticky |-> perr_n) and (!serr_sticky |-> serr_n));

endmodule

// File: tb/tb_bus_parity_unit.sv
`timescale 1ns/1ps
module tb_bus_parity_unit;

   typedef struct packed {
      logic [31:0] lo;
      logic [3:0]  blo;
      logic [31:0] hi;
      logic [3:0]  bhi;
      logic        a;
      logic        d;
      logic        oe;
      logic        rq;
      logic        ak;
      logic        p;
      logic        p64;
      logic        clr;
   } stim_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] ad_lo, ad_hi;
   logic [3:0]  cbe_lo_n, cbe_hi_n;
   logic ad_oe, addr_ph, data_ph, req64, ack64, par_in, par64_in, sticky_clr;
   logic par_out, par_oe, par64_out, par64_oe, perr_n, serr_n, perr_sticky, serr_sticky;

   always #2 clk = ~clk;

   bus_parity_unit dut (
      .clk(clk), .rst_n(rst_n), .ad_lo(ad_lo), .cbe_lo_n(cbe_lo_n),
      .ad_hi(ad_hi), .cbe_hi_n(cbe_hi_n), .ad_oe(ad_oe), .addr_ph(addr_ph),
      .data_ph(data_ph), .req64(req64), .ack64(ack64), .par_in(par_in),
      .par64_in(par64_in), .sticky_clr(sticky_clr), .par_out(par_out),
      .par_oe(par_oe), .par64_out(par64_out), .par64_oe(par64_oe),
      .perr_n(perr_n), .serr_n(serr_n), .perr_sticky(perr_sticky),
      .serr_sticky(serr_sticky)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   stim_t h1, h2;
   logic m_perr_st, m_serr_st;

   function automatic logic fp_lo(input stim_t s);
      return ^{s.lo, s.blo};
   endfunction
   function automatic logic fp_hi(input stim_t s);
      return ^{s.hi, s.bhi};
   endfunction
   function automatic logic fhiq(input stim_t s);
      return s.a ? s.rq : (s.d & s.rq & s.ak);
   endfunction

   function automatic stim_t idle_s();
      stim_t s;
      s = '0;
      return s;
   endfunction

   // parity bits of a stimulus cover the stimulus applied before it
   function automatic stim_t mk(input stim_t prev, input logic a, input logic d,
                                input logic oe, input logic rq, input logic ak,
                                input logic clr, input logic elo, input logic ehi);
      stim_t s;
      s.lo  = $urandom;
      s.blo = 4'($urandom);
      s.hi  = $urandom;
      s.bhi = 4'($urandom);
      s.a = a; s.d = d; s.oe = oe; s.rq = rq; s.ak = ak; s.clr = clr;
      s.p   = fp_lo(prev) ^ elo;
      s.p64 = fp_hi(prev) ^ ehi;
      return s;
   endfunction

   function automatic stim_t rnd(input stim_t prev);
      int ph;
      ph = int'($urandom % 8);
      return mk(prev, (ph == 1 || ph == 7), (ph == 2 || ph == 3 || ph == 7),
                ($urandom % 3) == 0, 1'($urandom), 1'($urandom),
                ($urandom % 8) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(input stim_t s);
      ad_lo = s.lo; cbe_lo_n = s.blo; ad_hi = s.hi; cbe_hi_n = s.bhi;
      addr_ph = s.a; data_ph = s.d; ad_oe = s.oe; req64 = s.rq; ack64 = s.ak;
      par_in = s.p; par64_in = s.p64; sticky_clr = s.clr;
   endtask

   task automatic step(input stim_t s);
      logic rxa, rxd, bad, e_perr, e_serr, e_hi_oe;
      @(negedge clk);
      rxa = h2.a & ~h2.oe;
      rxd = h2.d & ~h2.a & ~h2.oe;
      bad = (fp_lo(h2) != h1.p) | (fhiq(h2) & (fp_hi(h2) != h1.p64));
      e_perr = rxd & bad;
      e_serr = rxa & bad;
      m_perr_st = (m_perr_st & ~h1.clr) | e_perr;
      m_serr_st = (m_serr_st & ~h1.clr) | e_serr;
      e_hi_oe = h1.oe & fhiq(h1);
      chk("R2 par_oe", {31'd0, par_oe}, {31'd0, h1.oe});
      if (h1.oe) chk("R1 par_out", {31'd0, par_out}, {31'd0, fp_lo(h1)});
      chk("R3 par64_oe", {31'd0, par64_oe}, {31'd0, e_hi_oe});
      if (e_hi_oe) chk("R3 par64_out", {31'd0, par64_out}, {31'd0, fp_hi(h1)});
      chk("R4 R6 R7 perr_n", {31'd0, perr_n}, {31'd0, ~e_perr});
      chk("R5 R6 R7 serr_n", {31'd0, serr_n}, {31'd0, ~e_serr});
      chk("R8 perr_sticky", {31'd0, perr_sticky}, {31'd0, m_perr_st});
      chk("R8 serr_sticky", {31'd0, serr_sticky}, {31'd0, m_serr_st});
      apply(s);
      h2 = h1;
      h1 = s;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      h1 = idle_s();
      h2 = idle_s();
      m_perr_st = 1'b0;
      m_serr_st = 1'b0;
      apply(idle_s());
      repeat (3) @(negedge clk);
      // R9: state held in reset
      chk("R9 perr_n", {31'd0, perr_n}, 32'd1);
      chk("R9 serr_n", {31'd0, serr_n}, 32'd1);
      chk("R9 par_oe", {31'd0, par_oe}, 32'd0);
      chk("R9 par64_oe", {31'd0, par64_oe}, 32'd0);
      chk("R9 sticky", {30'd0, perr_sticky, serr_sticky}, 32'd0);
      rst_n = 1'b1;
      step(idle_s());
      step(idle_s());

      // R8: error pulse and clear on the same edge, flag must survive
      step(mk(h1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      step(mk(h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
      step(idle_s());
      step(idle_s());
      step(mk(h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
      step(idle_s());
      step(idle_s());

      // R5: both phase inputs high, bad parity goes to the address line
      step(mk(h1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      step(mk(h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
      step(idle_s());
      step(idle_s());

      // R6: upper parity wrong but wide transfer not acknowledged
      step(mk(h1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
      step(mk(h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
      step(idle_s());
      step(idle_s());
      // R6: same with acknowledge, now reported
      step(mk(h1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
      step(mk(h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
      step(idle_s());
      step(idle_s());

      // R7: self-driven data phase with wrong parity returned
      step(mk(h1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
      step(mk(h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
      step(idle_s());
      step(idle_s());

      // R1 R3: all byte enables deasserted still counted in parity
      begin
         stim_t s;
         s = mk(h1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
         s.blo = 4'hF;
         s.bhi = 4'hF;
         step(s);
         step(idle_s());
         step(idle_s());
      end

      for (int i = 0; i < 3000; i++) step(rnd(h1));
      step(idle_s());
      step(idle_s());

      done = 1'b1;
      summary();
      $finish;
   end

endmodule